// File: doc/BRIEF.md
# Big-Endian Byte Lane Steering Unit

This block connects a load/store path to a memory port that is one 32-bit word wide and byte addressed. On the store side it takes a byte address, an access size and the store value. It returns the word address, one write enable per byte lane, and write data already placed in the lanes the access covers. On the load side it takes the word read from memory, the low two address bits and the access size. It cuts out the addressed byte or halfword and widens it to 32 bits, with sign or zero extension.

Lanes follow big-endian order. The byte at offset 0 of a word is its most significant byte. Both sides test natural alignment and raise a flag when the offset is not a multiple of the access size. A misaligned store writes nothing.

Both sides are registered. A request presented in one cycle shows its result on the outputs after the next rising clock edge. Size encoding on both sides: 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 also treated as word.

Top module: `lane_steer_unit`

## Requirements
- R1: While rst_n is low at a rising edge, every output is cleared to zero at that edge.
- R2: Outputs show the request sampled at the previous rising edge. If st_valid was low, mem_we, mem_be, mem_wdata, mem_addr and st_misalign are zero. If ld_valid was low, ld_done, ld_data and ld_misalign are zero.
- R3: For a valid store, mem_addr equals st_addr with its two low bits cleared.
- R4: A byte store at offset k (0..3) sets only mem_be bit 3-k. It places st_wdata[7:0] at mem_wdata[31-8k:24-8k] and zeroes every other lane.
- R5: A halfword store at offset 0 gives mem_be 4'b1100 and st_wdata[15:0] at mem_wdata[31:16]. At offset 2 it gives mem_be 4'b0011 and st_wdata[15:0] at mem_wdata[15:0]. Other lanes are zero.
- R6: A word store (size 2'b10 or 2'b11) at offset 0 gives mem_be 4'b1111 and mem_wdata equal to st_wdata.
- R7: A store is misaligned when it is a halfword with address bit 0 set, or a word with either low bit set. It then gives st_misalign=1, mem_we=0, mem_be=0 and mem_wdata=0. A valid aligned store gives mem_we=1 and st_misalign=0.
- R8: A byte load at offset k takes ld_word[31-8k:24-8k]. With ld_signed=1 it copies bit 7 of that byte into bits 31:8. With ld_signed=0 those bits are zero.
- R9: A halfword load takes ld_word[31:16] at offset 0 and ld_word[15:0] at offset 2. It extends from bit 15 when ld_signed=1 and with zeros when ld_signed=0.
- R10: A word load at offset 0 returns ld_word unchanged, and ld_signed has no effect.
- R11: A valid load that breaks the alignment rule of R7 gives ld_misalign=1 and ld_data=0 and still raises ld_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Store request present |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| st_wdata | input | 32 | Store value, right-justified |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-placed write data |
| st_misalign | output | 1 | Store alignment fault |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | 2 | Low two bits of the load address |
| ld_size | input | 2 | Load size code |
| ld_signed | input | 1 | Sign-extend the load result |
| ld_word | input | 32 | Word read from memory |
| ld_done | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| ld_misalign | output | 1 | Load alignment fault |

## Verification
Several rules are checked by assertions on every cycle: a misaligned store never writes and never enables a lane, the memory address is always word aligned, and byte enables only take the legal shapes. The assertions also cover one-cycle alignment detection, halfword lane selection at offset 0, idle cycles, and the zeroed upper bits of an unsigned byte load. Other behaviour shows only in the bench's scenarios, where a behavioural model predicts each output from the request. This covers placing the correct value into each lane, choosing the correct source byte on a load, the sign fill of negative bytes and halfwords, and word loads with the signed flag set.

// File: rtl/lane_steer_pkg.sv
// Shared constants and the access-size encoding for the lane steering unit.
// Assumes a 32-bit data word split into four 8-bit lanes.
package lane_steer_pkg;
    localparam int DATA_W     = 32;
    localparam int LANE_W     = 8;
    localparam int LANES      = DATA_W / LANE_W;
    localparam int OFF_W      = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lane_align_check.sv
// Natural-alignment test for one access.
// Flags a halfword with an odd offset or a word with any nonzero offset.
// Byte accesses are always aligned. Size 2'b11 is handled like a word.
module lane_align_check
    import lane_steer_pkg::*;
(
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   off,
    output logic               misaligned
);
    // Compare the offset against the size's alignment mask.
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            default: misaligned = |off;
        endcase
    end
endmodule

// File: rtl/lane_store_pack.sv
// Builds byte enables and lane-placed write data for an aligned store.
// Lane i is byte offset i and maps to data bits [31-8i -: 8] (big-endian).
// The enable for lane i is bit LANES-1-i. The caller masks misaligned accesses.
module lane_store_pack
    import lane_steer_pkg::*;
(
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  wdata,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  lane_data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int       MSB_POS   = DATA_W - 1 - LANE_W * i;
        localparam logic     UPPER_HLF = (i < LANES / 2);
        localparam int       HALF_SRC  = (i % 2 == 0) ? LANE_W : 0;
        logic              hit;
        logic [LANE_W-1:0] src;

        // Decide whether this lane is covered and which source byte feeds it.
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    hit = (off == OFF_W'(i));
                    src = wdata[LANE_W-1:0];
                end
                SZ_HALF: begin
                    hit = (off[OFF_W-1] == ~UPPER_HLF);
                    src = wdata[HALF_SRC +: LANE_W];
                end
                default: begin
                    hit = 1'b1;
                    src = wdata[MSB_POS -: LANE_W];
                end
            endcase
        end

        assign be[LANES-1-i]               = hit;
        assign lane_data[MSB_POS -: LANE_W] = hit ? src : '0;
    end
endmodule

// File: rtl/lane_load_extract.sv
// Pulls the addressed byte or halfword out of a big-endian read word
// and widens it to 32 bits with sign or zero fill.
// Assumes the access is aligned. The caller zeroes misaligned results.
module lane_load_extract
    import lane_steer_pkg::*;
(
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   off,
    input  logic               sign_ext,
    input  logic [DATA_W-1:0]  word,
    output logic [DATA_W-1:0]  result
);
    logic [LANE_W-1:0]   sel_byte;
    logic [2*LANE_W-1:0] sel_half;

    // Select the byte lane named by the offset, offset 0 being the top lane.
    always_comb begin
        unique case (off)
            2'd0:    sel_byte = word[31:24];
            2'd1:    sel_byte = word[23:16];
            2'd2:    sel_byte = word[15:8];
            default: sel_byte = word[7:0];
        endcase
    end

    // Select the upper halfword for offset 0 and the lower one for offset 2.
    assign sel_half = off[1] ? word[15:0] : word[31:16];

    // Widen the selection according to size and signedness.
    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-LANE_W){sign_ext & sel_byte[LANE_W-1]}}, sel_byte};
            SZ_HALF: result = {{(DATA_W-2*LANE_W){sign_ext & sel_half[2*LANE_W-1]}}, sel_half};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/lane_steer_unit.sv
// Big-endian byte lane steering between a load/store path and a word-wide
// memory port. Store and load sides are independent and each has one
// register stage. Misaligned stores are suppressed, and misaligned loads
// return zero with a fault flag.
module lane_steer_unit
    import lane_steer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_valid,
    input  logic [ADDR_W-1:0]  st_addr,
    input  logic [1:0]         st_size,
    input  logic [DATA_W-1:0]  st_wdata,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]   mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               st_misalign,
    input  logic               ld_valid,
    input  logic [OFF_W-1:0]   ld_addr,
    input  logic [1:0]         ld_size,
    input  logic               ld_signed,
    input  logic [DATA_W-1:0]  ld_word,
    output logic               ld_done,
    output logic [DATA_W-1:0]  ld_data,
    output logic               ld_misalign
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(LANES - 1);

    acc_size_e          st_sz, ld_sz;
    logic [OFF_W-1:0]   st_off;
    logic               st_bad, ld_bad;
    logic [LANES-1:0]   pk_be;
    logic [DATA_W-1:0]  pk_data;
    logic [DATA_W-1:0]  ex_data;

    assign st_sz  = acc_size_e'(st_size);
    assign ld_sz  = acc_size_e'(ld_size);
    assign st_off = st_addr[OFF_W-1:0];

    lane_align_check u_st_align (.size(st_sz), .off(st_off),  .misaligned(st_bad));
    lane_align_check u_ld_align (.size(ld_sz), .off(ld_addr), .misaligned(ld_bad));

    lane_store_pack u_pack (
        .size(st_sz), .off(st_off), .wdata(st_wdata),
        .be(pk_be), .lane_data(pk_data)
    );

    lane_load_extract u_extract (
        .size(ld_sz), .off(ld_addr), .sign_ext(ld_signed),
        .word(ld_word), .result(ex_data)
    );

    // Register the store side. Idle or misaligned requests drive no lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we      <= 1'b0;
            mem_addr    <= '0;
            mem_be      <= '0;
            mem_wdata   <= '0;
            st_misalign <= 1'b0;
        end else begin
            mem_we      <= st_valid & ~st_bad;
            mem_addr    <= st_valid ? (st_addr & WORD_MASK) : '0;
            mem_be      <= (st_valid & ~st_bad) ? pk_be   : '0;
            mem_wdata   <= (st_valid & ~st_bad) ? pk_data : '0;
            st_misalign <= st_valid & st_bad;
        end
    end

    // Register the load side. A misaligned load returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_done     <= 1'b0;
            ld_data     <= '0;
            ld_misalign <= 1'b0;
        end else begin
            ld_done     <= ld_valid;
            ld_data     <= (ld_valid & ~ld_bad) ? ex_data : '0;
            ld_misalign <= ld_valid & ld_bad;
        end
    end
endmodule

// File: rtl/lane_steer_checks.sv
// Property checker for lane_steer_unit, attached with bind below.
// It observes only the ports of the unit.
module lane_steer_checks
    import lane_steer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               st_valid,
    input logic [ADDR_W-1:0]  st_addr,
    input logic [1:0]         st_size,
    input logic [DATA_W-1:0]  st_wdata,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [LANES-1:0]   mem_be,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic               st_misalign,
    input logic               ld_valid,
    input logic [OFF_W-1:0]   ld_addr,
    input logic [1:0]         ld_size,
    input logic               ld_signed,
    input logic [DATA_W-1:0]  ld_word,
    input logic               ld_done,
    input logic [DATA_W-1:0]  ld_data,
    input logic               ld_misalign
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> (!mem_we && mem_be == '0));

    p_word_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[OFF_W-1:0] == '0);

    p_be_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mem_be) <= 1) || mem_be == 4'b1100 ||
        mem_be == 4'b0011 || mem_be == 4'b1111);

    p_half_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_size == 2'b01 && st_addr[1:0] == 2'b00) |=> mem_be == 4'b1100);

    p_write_needs_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!st_misalign && mem_be != '0));

    p_fault_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_misalign |-> (!mem_we && mem_be == '0));

    p_word_offset_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_size[1] && st_addr[1:0] != 2'b00) |=> st_misalign);

    p_ubyte_zero_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_size == 2'b00 && !ld_signed) |=> ld_data[DATA_W-1:LANE_W] == '0);

    p_load_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_misalign |-> (ld_done && ld_data == '0));
endmodule

bind lane_steer_unit lane_steer_checks #(.ADDR_W(ADDR_W)) u_checks (.*);

// File: tb/lane_steer_unit_test.sv
// Self-checking bench. A behavioural model predicts every registered
// output from the request driven in the previous cycle.
module lane_steer_unit_test;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        st_valid;
    logic [31:0] st_addr;
    logic [1:0]  st_size;
    logic [31:0] st_wdata;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        st_misalign;
    logic        ld_valid;
    logic [1:0]  ld_addr;
    logic [1:0]  ld_size;
    logic        ld_signed;
    logic [31:0] ld_word;
    logic        ld_done;
    logic [31:0] ld_data;
    logic        ld_misalign;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    bit pending  = 0;

    logic        e_we, e_smis, e_done, e_lmis;
    logic [31:0] e_addr, e_wdata, e_ld;
    logic [3:0]  e_be;
    string       s_tag, l_tag, a_tag;

    always #2 clk = ~clk;

    lane_steer_unit #(.ADDR_W(AW)) uut (.*);

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(s_tag, "mem_we",      {31'b0, mem_we},      {31'b0, e_we});
        check(a_tag, "mem_addr",    mem_addr,             e_addr);
        check(s_tag, "mem_be",      {28'b0, mem_be},      {28'b0, e_be});
        check(s_tag, "mem_wdata",   mem_wdata,            e_wdata);
        check(s_tag, "st_misalign", {31'b0, st_misalign}, {31'b0, e_smis});
        check(l_tag, "ld_done",     {31'b0, ld_done},     {31'b0, e_done});
        check(l_tag, "ld_data",     ld_data,              e_ld);
        check(l_tag, "ld_misalign", {31'b0, ld_misalign}, {31'b0, e_lmis});
    endtask

    function automatic bit is_bad(input int sz, input int off);
        if (sz == 0) return 0;
        if (sz == 1) return (off % 2) != 0;
        return off != 0;
    endfunction

    task automatic model(input logic sv, input logic [31:0] sa, input logic [1:0] ss, input logic [31:0] sd,
                         input logic lv, input logic [1:0] la, input logic [1:0] lsz, input logic lsg, input logic [31:0] lw);
        int off, loff, sh;
        longint v;
        off = int'(sa) & 3;
        e_we = 0; e_addr = 0; e_be = 0; e_wdata = 0; e_smis = 0;
        if (!sv) begin
            s_tag = "R2"; a_tag = "R2";
        end else begin
            a_tag = "R3";
            e_addr = sa - 32'(off);
            if (is_bad(int'(ss), off)) begin
                s_tag = "R7"; e_smis = 1;
            end else begin
                e_we = 1;
                if (ss == 2'b00) begin
                    s_tag = "R4"; sh = 8 * (3 - off);
                    e_be = 4'(1 << (3 - off));
                    e_wdata = (sd & 32'hFF) << sh;
                end else if (ss == 2'b01) begin
                    s_tag = "R5";
                    e_be = (off == 0) ? 4'b1100 : 4'b0011;
                    e_wdata = (off == 0) ? ((sd & 32'hFFFF) << 16) : (sd & 32'hFFFF);
                end else begin
                    s_tag = "R6"; e_be = 4'b1111; e_wdata = sd;
                end
            end
        end
        loff = int'(la);
        e_done = lv; e_ld = 0; e_lmis = 0;
        if (!lv) l_tag = "R2";
        else if (is_bad(int'(lsz), loff)) begin
            l_tag = "R11"; e_lmis = 1;
        end else if (lsz == 2'b00) begin
            l_tag = "R8";
            v = (longint'(lw) >> (8 * (3 - loff))) & 255;
            if (lsg && v >= 128) v = v - 256;
            e_ld = 32'(v);
        end else if (lsz == 2'b01) begin
            l_tag = "R9";
            v = (longint'(lw) >> ((loff == 0) ? 16 : 0)) & 65535;
            if (lsg && v >= 32768) v = v - 65536;
            e_ld = 32'(v);
        end else begin
            l_tag = "R10"; e_ld = lw;
        end
    endtask

    task automatic cycle(input logic sv, input logic [31:0] sa, input logic [1:0] ss, input logic [31:0] sd,
                         input logic lv, input logic [1:0] la, input logic [1:0] lsz, input logic lsg, input logic [31:0] lw);
        @(negedge clk);
        if (pending) compare_all();
        st_valid = sv; st_addr = sa; st_size = ss; st_wdata = sd;
        ld_valid = lv; ld_addr = la; ld_size = lsz; ld_signed = lsg; ld_word = lw;
        model(sv, sa, ss, sd, lv, la, lsz, lsg, lw);
        pending = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        st_valid = 1; st_addr = 32'h1234_5678; st_size = 2'b10; st_wdata = 32'hDEAD_BEEF;
        ld_valid = 1; ld_addr = 0; ld_size = 2'b10; ld_signed = 0; ld_word = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: every output cleared while reset is held
        check("R1", "mem_we",      {31'b0, mem_we},      0);
        check("R1", "mem_addr",    mem_addr,             0);
        check("R1", "mem_be",      {28'b0, mem_be},      0);
        check("R1", "mem_wdata",   mem_wdata,            0);
        check("R1", "st_misalign", {31'b0, st_misalign}, 0);
        check("R1", "ld_done",     {31'b0, ld_done},     0);
        check("R1", "ld_data",     ld_data,              0);
        check("R1", "ld_misalign", {31'b0, ld_misalign}, 0);
        st_valid = 0; ld_valid = 0;
        rst_n = 1;

        // R2: idle cycle with busy data inputs
        cycle(0, 32'hFFFF_FFFF, 2'b10, 32'hFFFF_FFFF, 0, 2'd0, 2'b10, 1, 32'hFFFF_FFFF);
        // R3..R11: every size at every offset, with negative and positive lanes
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 4; off++) begin
                cycle(1, 32'h0000_4A40 + 32'(off), 2'(sz), 32'hA1B2_C3D4,
                      1, 2'(off), 2'(sz), 1, 32'h8A7F_C135);
                cycle(1, 32'hFFFF_FFF0 + 32'(off), 2'(sz), 32'h5E6F_7788,
                      1, 2'(off), 2'(sz), 0, 32'h8A7F_C135);
                cycle(1, 32'h0000_0100 + 32'(off), 2'(sz), 32'h0102_8384,
                      1, 2'(off), 2'(sz), 1, 32'h7FF0_0F81);
            end
        end
        // R10: signed flag on a word load with MSB set has no effect
        cycle(0, 0, 2'b00, 0, 1, 2'd0, 2'b10, 1, 32'hF000_0001);
        // Random mix of requests
        for (int k = 0; k < 400; k++) begin
            cycle(1'($urandom), $urandom, 2'($urandom), $urandom,
                  1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), $urandom);
        end
        cycle(0, 0, 2'b00, 0, 0, 2'd0, 2'b00, 0, 0);
        @(negedge clk);
        compare_all();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule